// File: doc/BRIEF.md
# Card Clock Control and Interrupt Router

This block belongs to a memory-card host controller. It keeps the card clock run/halt state, a request register of thirteen interrupt sources with a matching mask register, and it routes pending requests to one processor interrupt line and two DMA request lines (receive and transmit). Other parts of the controller raise and clear individual request bits through set and clear vectors. The register decoder turns software writes into a start/stop strobe and a mask write.

A start write turns the card clock on and withdraws the clock-off request. If a command is waiting and the control word does not have its stop-transfer flag set, the start write also pulses `cmd_launch`. The command sequencer uses that pulse to issue the command and to trim its status down to the clock-enable flag. A stop write turns the clock off, raises the clock-off request and pulses `act_abort` so that the data path drops any transfer in progress. When DMA mode is on, the receive and transmit FIFO service requests reach only the DMA lines and are hidden from the processor interrupt. The DMA lines always follow their request bits, whatever the mask says.

Top module: `clkirq_top`

## Requirements
- R1: After reset, `clk_en`, `cmd_launch`, `act_abort`, `irq_req`, `irq_mask`, `cpu_irq`, `rx_dma_req` and `tx_dma_req` are all zero.
- R2: A cycle with `msk_wr` high loads `msk_wdata` into `irq_mask`, which is visible after the next clock edge. Without `msk_wr` the mask holds its value.
- R3: Each bit k of `irq_req` is set after the edge at which `req_set[k]` is high and cleared after the edge at which `req_clr[k]` is high. When both are high in the same cycle, the set wins.
- R4: `cpu_irq` is high exactly when some bit of `irq_req` is set whose effective mask bit is 0. It is registered, so it reflects `irq_req` and `irq_mask` as they stood one cycle earlier.
- R5: With `dma_en` high, the effective mask is `irq_mask` with bit 5 (receive FIFO request) and bit 6 (transmit FIFO request) forced to 1. With `dma_en` low, the effective mask is `irq_mask` alone. The effect appears one edge after `dma_en` changes.
- R6: `rx_dma_req` follows `irq_req` bit 5 and `tx_dma_req` follows bit 6, one cycle later, regardless of mask and `dma_en`.
- R7: A start/stop write with `ss_start` high and `ss_stop` low sets `clk_en` and clears request bit 4 (clock off) at the next edge.
- R8: `cmd_launch` pulses for exactly one cycle after a start write made while `cmd_pending` is high and `stop_xfer` is low. It stays low otherwise.
- R9: A start/stop write with `ss_stop` high clears `clk_en`, sets request bit 4 and pulses `act_abort` for one cycle after the next edge.
- R10: When `ss_start` and `ss_stop` are written together, the stop prevails: `clk_en` ends 0 and bit 4 ends 1. A launch still pulses if the R8 conditions hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ss_wr | input | 1 | Start/stop register write strobe |
| ss_start | input | 1 | Start-clock bit of the write data |
| ss_stop | input | 1 | Stop-clock bit of the write data |
| cmd_pending | input | 1 | A command is waiting to be issued |
| stop_xfer | input | 1 | Stop-transfer flag of the control word |
| dma_en | input | 1 | DMA mode flag of the control word |
| msk_wr | input | 1 | Mask register write strobe |
| msk_wdata | input | 13 | Mask write data |
| req_set | input | 13 | Per-bit request set pulses |
| req_clr | input | 13 | Per-bit request clear pulses |
| clk_en | output | 1 | Card clock enabled |
| cmd_launch | output | 1 | One-cycle command launch pulse |
| act_abort | output | 1 | One-cycle activity abort pulse |
| irq_req | output | 13 | Request register |
| irq_mask | output | 13 | Mask register |
| cpu_irq | output | 1 | Processor interrupt |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |

## Verification
Two functions can meet in one cycle: the clock controller's own set and clear of the clock-off request bit, and the other logic's clear pulses on that same bit. The bench provokes this by writing start and stop together, and by writing stop while `req_clr` also targets bit 4. It judges that the stop outcome (bit set, clock off) survives and that a pending launch still fires. The routing is swept over every single-bit request against every single-bit mask in both DMA modes.

// File: rtl/clkirq_pkg.sv
package clkirq_pkg;
  localparam int NREQ       = 13;
  localparam int RX_BIT     = 5;
  localparam int TX_BIT     = 6;
  localparam int CLKOFF_BIT = 4;

  typedef logic [NREQ-1:0] req_t;

  localparam req_t FIFO_BITS = req_t'((1 << RX_BIT) | (1 << TX_BIT));

  // effective mask seen by the processor line
  function automatic req_t eff_mask(input req_t mask, input logic dma);
    return dma ? (mask | FIFO_BITS) : mask;
  endfunction

  // next request value: clear first, then set, so set wins
  function automatic req_t req_next(input req_t cur, input req_t set, input req_t clr);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic any_unmasked(input req_t req, input req_t emask);
    return |(req & ~emask);
  endfunction
endpackage

// File: rtl/clkirq_clkctl.sv
module clkirq_clkctl
  import clkirq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ss_wr,
  input  logic ss_start,
  input  logic ss_stop,
  input  logic cmd_pending,
  input  logic stop_xfer,
  output logic clk_en,
  output logic cmd_launch,
  output logic act_abort,
  output req_t co_set,
  output req_t co_clr
);
  // named internal events
  logic ev_start, ev_stop, ev_launch;

  assign ev_start  = ss_wr & ss_start;
  assign ev_stop   = ss_wr & ss_stop;
  assign ev_launch = ev_start & cmd_pending & ~stop_xfer;

  always_comb begin
    co_set = '0;
    co_clr = '0;
    co_set[CLKOFF_BIT] = ev_stop;
    co_clr[CLKOFF_BIT] = ev_start;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_en     <= 1'b0;
      cmd_launch <= 1'b0;
      act_abort  <= 1'b0;
    end else begin
      if (ev_stop)       clk_en <= 1'b0;
      else if (ev_start) clk_en <= 1'b1;
      cmd_launch <= ev_launch;
      act_abort  <= ev_stop;
    end
  end

  AST_START_SETS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_wr && ss_start && !ss_stop) |=> clk_en); // R7
  AST_STOP_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_wr && ss_stop) |=> (!clk_en && act_abort)); // R9
  AST_LAUNCH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_launch |-> $past(ss_wr && ss_start && cmd_pending && !stop_xfer)); // R8
  AST_NO_SPURIOUS_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!ss_wr) |=> !cmd_launch); // R8
endmodule

// File: rtl/clkirq_reqreg.sv
module clkirq_reqreg
  import clkirq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  req_t ext_set,
  input  req_t ext_clr,
  input  req_t co_set,
  input  req_t co_clr,
  input  logic msk_wr,
  input  req_t msk_wdata,
  output req_t req_q,
  output req_t mask_q
);
  req_t all_set, all_clr;

  assign all_set = ext_set | co_set;
  assign all_clr = ext_clr | co_clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= '0;
      mask_q <= '0;
    end else begin
      req_q <= req_next(req_q, all_set, all_clr);
      if (msk_wr) mask_q <= msk_wdata;
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|all_set) |=> ((req_q & $past(all_set)) == $past(all_set))); // R3
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!msk_wr) |=> $stable(mask_q)); // R2
endmodule

// File: rtl/clkirq_route.sv
module clkirq_route
  import clkirq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  req_t req_q,
  input  req_t mask_q,
  input  logic dma_en,
  output logic cpu_irq,
  output logic rx_dma_req,
  output logic tx_dma_req
);
  req_t emask;
  assign emask = eff_mask(mask_q, dma_en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_irq    <= 1'b0;
      rx_dma_req <= 1'b0;
      tx_dma_req <= 1'b0;
    end else begin
      cpu_irq    <= any_unmasked(req_q, emask);
      rx_dma_req <= req_q[RX_BIT];
      tx_dma_req <= req_q[TX_BIT];
    end
  end

  AST_DMA_HIDES_FIFO: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_en && ((req_q & ~mask_q & ~FIFO_BITS) == '0)) |=> !cpu_irq); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q == '0) |=> !cpu_irq); // R4
  AST_RX_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    req_q[RX_BIT] |=> rx_dma_req); // R6
  AST_TX_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !req_q[TX_BIT] |=> !tx_dma_req); // R6
endmodule

// File: rtl/clkirq_top.sv
module clkirq_top
  import clkirq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ss_wr,
  input  logic            ss_start,
  input  logic            ss_stop,
  input  logic            cmd_pending,
  input  logic            stop_xfer,
  input  logic            dma_en,
  input  logic            msk_wr,
  input  logic [NREQ-1:0] msk_wdata,
  input  logic [NREQ-1:0] req_set,
  input  logic [NREQ-1:0] req_clr,
  output logic            clk_en,
  output logic            cmd_launch,
  output logic            act_abort,
  output logic [NREQ-1:0] irq_req,
  output logic [NREQ-1:0] irq_mask,
  output logic            cpu_irq,
  output logic            rx_dma_req,
  output logic            tx_dma_req
);
  req_t co_set, co_clr, req_q, mask_q;

  clkirq_clkctl u_clk (
    .clk(clk), .rst_n(rst_n), .ss_wr(ss_wr), .ss_start(ss_start), .ss_stop(ss_stop),
    .cmd_pending(cmd_pending), .stop_xfer(stop_xfer), .clk_en(clk_en),
    .cmd_launch(cmd_launch), .act_abort(act_abort), .co_set(co_set), .co_clr(co_clr)
  );

  clkirq_reqreg u_req (
    .clk(clk), .rst_n(rst_n), .ext_set(req_set), .ext_clr(req_clr),
    .co_set(co_set), .co_clr(co_clr), .msk_wr(msk_wr), .msk_wdata(msk_wdata),
    .req_q(req_q), .mask_q(mask_q)
  );

  clkirq_route u_route (
    .clk(clk), .rst_n(rst_n), .req_q(req_q), .mask_q(mask_q), .dma_en(dma_en),
    .cpu_irq(cpu_irq), .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req)
  );

  assign irq_req  = req_q;
  assign irq_mask = mask_q;

  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_wr && ss_stop) |=> (irq_req[CLKOFF_BIT] && !clk_en)); // R10
endmodule

// File: tb/tb_clkirq_top.sv
`timescale 1ns/1ps
module tb_clkirq_top;
  localparam int N = 13;

  logic clk = 1'b0;
  logic rst_n;
  logic ss_wr, ss_start, ss_stop, cmd_pending, stop_xfer, dma_en, msk_wr;
  logic [N-1:0] msk_wdata, req_set, req_clr;
  logic clk_en, cmd_launch, act_abort, cpu_irq, rx_dma_req, tx_dma_req;
  logic [N-1:0] irq_req, irq_mask;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  clkirq_top dut (
    .clk(clk), .rst_n(rst_n), .ss_wr(ss_wr), .ss_start(ss_start), .ss_stop(ss_stop),
    .cmd_pending(cmd_pending), .stop_xfer(stop_xfer), .dma_en(dma_en),
    .msk_wr(msk_wr), .msk_wdata(msk_wdata), .req_set(req_set), .req_clr(req_clr),
    .clk_en(clk_en), .cmd_launch(cmd_launch), .act_abort(act_abort),
    .irq_req(irq_req), .irq_mask(irq_mask), .cpu_irq(cpu_irq),
    .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    ss_wr = 0; ss_start = 0; ss_stop = 0; msk_wr = 0;
    req_set = '0; req_clr = '0;
  endtask

  // expected processor line computed arithmetically
  function automatic logic exp_irq(input int rb, input int mb, input logic d);
    if (rb == mb) return 1'b0;
    if (d && (rb == 5 || rb == 6)) return 1'b0;
    return 1'b1;
  endfunction

  initial begin
    #50000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; cmd_pending = 0; stop_xfer = 0; dma_en = 0; msk_wdata = '0;
    idle();
    tick(); tick();
    rst_n = 1;
    tick();
    // R1 reset state
    chk("R1 clk_en", clk_en, 0);
    chk("R1 irq_req", irq_req, 0);
    chk("R1 irq_mask", irq_mask, 0);
    chk("R1 outs", {cpu_irq, rx_dma_req, tx_dma_req, cmd_launch, act_abort}, 0);

    // R2/R3/R4/R5/R6 sweep: single request bit vs single mask bit, both DMA modes
    for (int d = 0; d < 2; d++) begin
      for (int rb = 0; rb < N; rb++) begin
        for (int mb = 0; mb < N; mb++) begin
          dma_en = d[0];
          req_clr = '1; req_set = N'(1) << rb;
          msk_wr = 1; msk_wdata = N'(1) << mb;
          tick();
          idle();
          chk("R3 req", irq_req, N'(1) << rb);
          chk("R2 mask", irq_mask, N'(1) << mb);
          tick();
          chk("R4/R5 cpu_irq", cpu_irq, exp_irq(rb, mb, d[0]));
          chk("R6 rx_dma", rx_dma_req, rb == 5);
          chk("R6 tx_dma", tx_dma_req, rb == 6);
        end
      end
    end
    dma_en = 0;
    msk_wdata = 13'h1abc; tick(); // no msk_wr: R2 hold
    chk("R2 hold", irq_mask, N'(1) << 12);

    // R3 clear without set
    req_clr = '1; tick(); idle();
    chk("R3 clear", irq_req, 0);

    // R7 start, no pending
    ss_wr = 1; ss_start = 1; tick(); idle();
    chk("R7 clk_en", clk_en, 1);
    chk("R8 no launch", cmd_launch, 0);

    // R9 stop with simultaneous external clear on bit 4
    ss_wr = 1; ss_stop = 1; req_clr = N'(1) << 4; tick(); idle();
    chk("R9 clk_en", clk_en, 0);
    chk("R9 clkoff bit", irq_req[4], 1);
    chk("R9 abort", act_abort, 1);
    tick();
    chk("R9 abort one cycle", act_abort, 0);
    chk("R4 clkoff irq", cpu_irq, 1);

    // R7 start clears clock-off; R8 launch with pending
    cmd_pending = 1;
    ss_wr = 1; ss_start = 1; tick(); idle();
    chk("R7 clkoff cleared", irq_req[4], 0);
    chk("R8 launch", cmd_launch, 1);
    tick();
    chk("R8 launch one cycle", cmd_launch, 0);

    // R8 stop_xfer blocks launch
    stop_xfer = 1;
    ss_wr = 1; ss_start = 1; tick(); idle();
    chk("R8 stop_xfer blocks", cmd_launch, 0);
    stop_xfer = 0;

    // R10 start and stop together
    ss_wr = 1; ss_start = 1; ss_stop = 1; tick(); idle();
    chk("R10 clk_en", clk_en, 0);
    chk("R10 clkoff bit", irq_req[4], 1);
    chk("R10 launch", cmd_launch, 1);
    chk("R10 abort", act_abort, 1);
    cmd_pending = 0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule